// File: doc/BRIEF.md
# Unlock-Gated Protected Register Front End

This block is the software-facing register front end of a nonvolatile memory controller. It decodes a simple 32-bit word bus (address, write enable, write data, combinational read data). It holds the controller's configuration: a control register, three timing words, an operation address, a program-buffer index and two redundancy words. When software writes command bits to the control register, the block sends one-cycle command strobes to the erase/program engine. Writes to the program-buffer data offset are forwarded to the buffer as one-cycle write pulses that carry a self-incrementing slot number.

A write-protect flag comes up set out of reset. While it is set, every ordinary register write is dropped, and each dropped write sets a sticky error flag in the status register. Software clears that flag by writing a 1 to its bit. The protect flag can be changed only by the first control write that follows a fixed three-write key sequence. The sequence restarts from its first step if any bus write in between is wrong.

Top module: `nvmr_protreg_if`

## Requirements
- R1: After reset the protect flag is 1 (control reads 0x2), the sticky error is 0, no command strobe or buffer pulse is active, and every other stored register reads 0.
- R2: While the protect flag is 1 and no key sequence is open, writes to control (0x00), timing (0x04/0x08/0x0C), address (0x20), buffer data (0x24), buffer index (0x28) and redundancy (0x30/0x34) change nothing and fire no strobe or buffer pulse. Each such write sets status bit 1 from the next cycle on.
- R3: Writing 0x7123 to 0x18, then 0x812A to 0x1C, then 0xBEE1 to 0x18 opens the key. The next control write then applies all of its fields, including bit 1 (protect) and bit 0 (sleep).
- R4: A wrong value, a write to another offset, or a repeated step in the middle of the key sequence sends it back to the first step. A following control write is then still blocked.
- R5: An open key stays open across writes to other offsets and is used up by the next control write, whether or not that write changes the protect flag. A second control write cannot change the protect flag.
- R6: With the protect flag 0 and no open key, a control write updates the sleep bit and fires commands. It leaves the protect flag unchanged and does not set the error.
- R7: The status (0x2C) and key (0x18/0x1C) offsets are never blocked. Writing status with bit 1 = 1 clears the sticky error. Writing bit 1 = 0 leaves it unchanged.
- R8: Status bit 0 shows the engine busy input, bit 2 the redundancy-disable input, bit 3 the discharged input and bit 4 the brown-out input.
- R9: An accepted control write pulses cmd_strobe for exactly the cycle after the write. cmd_strobe[k] mirrors control bit 3+k: 3 mass erase, 4 page erase, 5 program, 6 reference erase, 7 trim recall, 8 auto-program. Control reads return those bits as 0.
- R10: A buffer-index write sets the slot counter. Each accepted buffer-data write pulses buf_wr in the next cycle, with buf_slot equal to the counter and buf_wdata equal to the data. The counter then increments and wraps from 7 to 0.
- R11: Timing, address and redundancy registers read back what was written, and timing_cfg shows word i of the timing registers at bits [32i+31:32i]. Unmapped offsets and the key offsets read 0, and writes to unmapped offsets set no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte offset of the accessed register |
| bus_we | input | 1 | Write enable, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| eng_busy | input | 1 | Engine busy indication |
| redun_off | input | 1 | Redundancy disabled indication |
| discharged | input | 1 | Discharged indication |
| brown_out | input | 1 | Brown-out indication |
| sleep_en | output | 1 | Sleep request |
| wr_protect | output | 1 | Current protect flag |
| cmd_strobe | output | 6 | One-cycle command strobes |
| timing_cfg | output | 96 | Timing words, word i at [32i+31:32i] |
| op_addr | output | 32 | Operation address |
| buf_wr | output | 1 | Program buffer write pulse |
| buf_slot | output | 3 | Slot index for buf_wr |
| buf_wdata | output | 32 | Data for buf_wr |

## Verification
The key sequencer cannot be read directly. A sequencer stuck open or stuck early shows up only at the next control write: it either accepts a write that should be blocked, so the protect flag and control readback change in the following cycle, or it rejects a proper one, so status bit 1 rises one cycle later. The bench therefore follows every sequence variant with a control write and reads control and status back. A wrong protect or error state is visible on the read port in the cycle after the offending write. A wrong slot counter shows at the next buffer pulse and at the index readback.

// File: rtl/nvmr_pkg.sv
package nvmr_pkg;
  localparam logic [5:0] OFS_CTRL   = 6'h00;
  localparam logic [5:0] OFS_TIM0   = 6'h04;
  localparam logic [5:0] OFS_KEY_A  = 6'h18;
  localparam logic [5:0] OFS_KEY_B  = 6'h1C;
  localparam logic [5:0] OFS_ADDR   = 6'h20;
  localparam logic [5:0] OFS_BDATA  = 6'h24;
  localparam logic [5:0] OFS_BIDX   = 6'h28;
  localparam logic [5:0] OFS_STAT   = 6'h2C;
  localparam logic [5:0] OFS_RED0   = 6'h30;

  localparam logic [31:0] KEY_STEP1 = 32'h0000_7123;
  localparam logic [31:0] KEY_STEP2 = 32'h0000_812A;
  localparam logic [31:0] KEY_STEP3 = 32'h0000_BEE1;

  localparam int CB_SLEEP  = 0;
  localparam int CB_WP     = 1;
  localparam int CB_CMD_LO = 3;

  localparam int SB_BUSY  = 0;
  localparam int SB_WPERR = 1;
  localparam int SB_REDOFF = 2;
  localparam int SB_DISCH = 3;
  localparam int SB_BROWN = 4;

  typedef enum logic [1:0] {
    KS_IDLE,
    KS_GOT1,
    KS_GOT2,
    KS_OPEN
  } key_state_e;
endpackage

// File: rtl/nvmr_key_seq.sv
module nvmr_key_seq
  import nvmr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              key_open
);
  key_state_e st_q, st_d;
  logic hit1, hit2, hit3, ctrl_wr;

  always_comb begin
    hit1    = (wr_addr == ADDR_W'(OFS_KEY_A)) && (wr_data == DATA_W'(KEY_STEP1));
    hit2    = (wr_addr == ADDR_W'(OFS_KEY_B)) && (wr_data == DATA_W'(KEY_STEP2));
    hit3    = (wr_addr == ADDR_W'(OFS_KEY_A)) && (wr_data == DATA_W'(KEY_STEP3));
    ctrl_wr = (wr_addr == ADDR_W'(OFS_CTRL));
  end

  always_comb begin
    st_d = st_q;
    if (wr_en) begin
      unique case (st_q)
        KS_IDLE: st_d = hit1 ? KS_GOT1 : KS_IDLE;
        KS_GOT1: st_d = hit2 ? KS_GOT2 : KS_IDLE;
        KS_GOT2: st_d = hit3 ? KS_OPEN : KS_IDLE;
        KS_OPEN: st_d = ctrl_wr ? KS_IDLE : KS_OPEN;
        default: st_d = KS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_IDLE;
    else        st_q <= st_d;
  end

  assign key_open = (st_q == KS_OPEN);
endmodule

// File: rtl/nvmr_status.sv
module nvmr_status
  import nvmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_set,
  input  logic              clr_req,
  input  logic              eng_busy,
  input  logic              redun_off,
  input  logic              discharged,
  input  logic              brown_out,
  output logic              err_flag,
  output logic [DATA_W-1:0] status_word
);
  logic err_q, err_d;

  always_comb begin
    err_d = err_q;
    if (clr_req) err_d = 1'b0;
    if (err_set) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  always_comb begin
    status_word            = '0;
    status_word[SB_BUSY]   = eng_busy;
    status_word[SB_WPERR]  = err_q;
    status_word[SB_REDOFF] = redun_off;
    status_word[SB_DISCH]  = discharged;
    status_word[SB_BROWN]  = brown_out;
  end

  assign err_flag = err_q;
endmodule

// File: rtl/nvmr_cfg_regs.sv
module nvmr_cfg_regs
  import nvmr_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 3,
  parameter int NUM_CMD    = 6,
  parameter int NUM_TIMING = 3,
  parameter int NUM_REDUN  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_ok,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         key_open,
  output logic                         sleep_en,
  output logic                         wr_protect,
  output logic [DATA_W-1:0]            ctrl_word,
  output logic [NUM_CMD-1:0]           cmd_strobe,
  output logic [NUM_TIMING*DATA_W-1:0] timing_flat,
  output logic [NUM_REDUN*DATA_W-1:0]  redun_flat,
  output logic [DATA_W-1:0]            op_addr,
  output logic [IDX_W-1:0]             buf_idx,
  output logic                         buf_wr,
  output logic [IDX_W-1:0]             buf_slot,
  output logic [DATA_W-1:0]            buf_wdata
);
  logic hit_ctrl, hit_addr, hit_bdata, hit_bidx;
  logic sleep_q, sleep_d, wp_q, wp_d;
  logic [NUM_CMD-1:0] cmd_q, cmd_d;
  logic [DATA_W-1:0]  addr_q, addr_d, bwd_q, bwd_d;
  logic [IDX_W-1:0]   idx_q, idx_d, slot_q, slot_d;
  logic               bwr_q, bwr_d;

  always_comb begin
    hit_ctrl  = wr_ok && (wr_addr == ADDR_W'(OFS_CTRL));
    hit_addr  = wr_ok && (wr_addr == ADDR_W'(OFS_ADDR));
    hit_bdata = wr_ok && (wr_addr == ADDR_W'(OFS_BDATA));
    hit_bidx  = wr_ok && (wr_addr == ADDR_W'(OFS_BIDX));
  end

  always_comb begin
    sleep_d = sleep_q;
    wp_d    = wp_q;
    cmd_d   = '0;
    if (hit_ctrl) begin
      sleep_d = wr_data[CB_SLEEP];
      if (key_open) wp_d = wr_data[CB_WP];
      cmd_d   = wr_data[CB_CMD_LO +: NUM_CMD];
    end
  end

  always_comb begin
    addr_d = hit_addr ? wr_data : addr_q;
    idx_d  = idx_q;
    bwr_d  = 1'b0;
    slot_d = slot_q;
    bwd_d  = bwd_q;
    if (hit_bidx) idx_d = wr_data[IDX_W-1:0];
    if (hit_bdata) begin
      bwr_d  = 1'b1;
      slot_d = idx_q;
      bwd_d  = wr_data;
      idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b0;
      wp_q    <= 1'b1;
      cmd_q   <= '0;
      addr_q  <= '0;
      idx_q   <= '0;
      bwr_q   <= 1'b0;
      slot_q  <= '0;
      bwd_q   <= '0;
    end else begin
      sleep_q <= sleep_d;
      wp_q    <= wp_d;
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
      idx_q   <= idx_d;
      bwr_q   <= bwr_d;
      slot_q  <= slot_d;
      bwd_q   <= bwd_d;
    end
  end

  for (genvar g = 0; g < NUM_TIMING; g++) begin : g_tim
    logic [DATA_W-1:0] tim_q, tim_d;
    always_comb begin
      tim_d = tim_q;
      if (wr_ok && (wr_addr == ADDR_W'(int'(OFS_TIM0) + 4*g))) tim_d = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tim_q <= '0;
      else        tim_q <= tim_d;
    end
    assign timing_flat[g*DATA_W +: DATA_W] = tim_q;
  end

  for (genvar g = 0; g < NUM_REDUN; g++) begin : g_red
    logic [DATA_W-1:0] red_q, red_d;
    always_comb begin
      red_d = red_q;
      if (wr_ok && (wr_addr == ADDR_W'(int'(OFS_RED0) + 4*g))) red_d = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) red_q <= '0;
      else        red_q <= red_d;
    end
    assign redun_flat[g*DATA_W +: DATA_W] = red_q;
  end

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[CB_SLEEP] = sleep_q;
    ctrl_word[CB_WP]    = wp_q;
  end

  assign sleep_en   = sleep_q;
  assign wr_protect = wp_q;
  assign cmd_strobe = cmd_q;
  assign op_addr    = addr_q;
  assign buf_idx    = idx_q;
  assign buf_wr     = bwr_q;
  assign buf_slot   = slot_q;
  assign buf_wdata  = bwd_q;
endmodule

// File: rtl/nvmr_protreg_if.sv
module nvmr_protreg_if
  import nvmr_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 3,
  parameter int NUM_CMD    = 6,
  parameter int NUM_TIMING = 3,
  parameter int NUM_REDUN  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic                         bus_we,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  input  logic                         eng_busy,
  input  logic                         redun_off,
  input  logic                         discharged,
  input  logic                         brown_out,
  output logic                         sleep_en,
  output logic                         wr_protect,
  output logic [NUM_CMD-1:0]           cmd_strobe,
  output logic [NUM_TIMING*DATA_W-1:0] timing_cfg,
  output logic [DATA_W-1:0]            op_addr,
  output logic                         buf_wr,
  output logic [IDX_W-1:0]             buf_slot,
  output logic [DATA_W-1:0]            buf_wdata
);
  localparam int RED_BITS = NUM_REDUN * DATA_W;

  logic sel_ctrl, sel_stat, sel_tim, sel_red, sel_prot;
  logic key_open, wr_blocked, wr_ok, err_flag;
  logic [DATA_W-1:0]   ctrl_word, status_word;
  logic [RED_BITS-1:0] redun_flat;
  logic [IDX_W-1:0]    buf_idx;

  always_comb begin
    sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
    sel_stat = (bus_addr == ADDR_W'(OFS_STAT));
    sel_tim  = 1'b0;
    for (int i = 0; i < NUM_TIMING; i++)
      if (bus_addr == ADDR_W'(int'(OFS_TIM0) + 4*i)) sel_tim = 1'b1;
    sel_red  = 1'b0;
    for (int i = 0; i < NUM_REDUN; i++)
      if (bus_addr == ADDR_W'(int'(OFS_RED0) + 4*i)) sel_red = 1'b1;
    sel_prot = sel_ctrl || sel_tim || sel_red
            || (bus_addr == ADDR_W'(OFS_ADDR))
            || (bus_addr == ADDR_W'(OFS_BDATA))
            || (bus_addr == ADDR_W'(OFS_BIDX));
    wr_blocked = sel_prot && wr_protect && !(sel_ctrl && key_open);
    wr_ok      = bus_we && sel_prot && !wr_blocked;
  end

  nvmr_key_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_we),
    .wr_addr  (bus_addr),
    .wr_data  (bus_wdata),
    .key_open (key_open)
  );

  nvmr_status #(.DATA_W(DATA_W)) u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_set     (bus_we && wr_blocked),
    .clr_req     (bus_we && sel_stat && bus_wdata[SB_WPERR]),
    .eng_busy    (eng_busy),
    .redun_off   (redun_off),
    .discharged  (discharged),
    .brown_out   (brown_out),
    .err_flag    (err_flag),
    .status_word (status_word)
  );

  nvmr_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_CMD(NUM_CMD),
    .NUM_TIMING(NUM_TIMING), .NUM_REDUN(NUM_REDUN)
  ) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ok       (wr_ok),
    .wr_addr     (bus_addr),
    .wr_data     (bus_wdata),
    .key_open    (key_open),
    .sleep_en    (sleep_en),
    .wr_protect  (wr_protect),
    .ctrl_word   (ctrl_word),
    .cmd_strobe  (cmd_strobe),
    .timing_flat (timing_cfg),
    .redun_flat  (redun_flat),
    .op_addr     (op_addr),
    .buf_idx     (buf_idx),
    .buf_wr      (buf_wr),
    .buf_slot    (buf_slot),
    .buf_wdata   (buf_wdata)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl) bus_rdata = ctrl_word;
    if (sel_stat) bus_rdata = status_word;
    if (bus_addr == ADDR_W'(OFS_ADDR)) bus_rdata = op_addr;
    if (bus_addr == ADDR_W'(OFS_BIDX)) bus_rdata = DATA_W'(buf_idx);
    for (int i = 0; i < NUM_TIMING; i++)
      if (bus_addr == ADDR_W'(int'(OFS_TIM0) + 4*i)) bus_rdata = timing_cfg[i*DATA_W +: DATA_W];
    for (int i = 0; i < NUM_REDUN; i++)
      if (bus_addr == ADDR_W'(int'(OFS_RED0) + 4*i)) bus_rdata = redun_flat[i*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/nvmr_protreg_chk.sv
module nvmr_protreg_chk
  import nvmr_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 3,
  parameter int NUM_CMD = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_we,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               wr_protect,
  input logic               key_open,
  input logic               wr_blocked,
  input logic               err_flag,
  input logic [NUM_CMD-1:0] cmd_strobe,
  input logic               buf_wr,
  input logic [IDX_W-1:0]   buf_slot
);
  logic ctrl_wr, stat_clr;
  assign ctrl_wr  = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
  assign stat_clr = bus_we && (bus_addr == ADDR_W'(OFS_STAT)) && bus_wdata[SB_WPERR];

  assert_block_sets_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && wr_blocked) |=> err_flag);

  assert_key_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(key_open) |-> $past(ctrl_wr));

  assert_wp_needs_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_protect) |-> $past(ctrl_wr && key_open));

  assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_flag) |-> $past(stat_clr));

  assert_cmd_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_strobe) |-> $past(ctrl_wr));

  assert_cmd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cmd_strobe) && !ctrl_wr) |=> (cmd_strobe == '0));

  assert_slot_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && $past(buf_wr)) |-> (buf_slot == $past(buf_slot) + 1'b1));
endmodule

bind nvmr_protreg_if nvmr_protreg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_CMD(NUM_CMD)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .bus_wdata  (bus_wdata),
  .wr_protect (wr_protect),
  .key_open   (key_open),
  .wr_blocked (wr_blocked),
  .err_flag   (err_flag),
  .cmd_strobe (cmd_strobe),
  .buf_wr     (buf_wr),
  .buf_slot   (buf_slot)
);

// File: tb/tb_nvmr_protreg_if.sv
module tb_nvmr_protreg_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_busy = 1'b0, redun_off = 1'b0, discharged = 1'b0, brown_out = 1'b0;
  logic        sleep_en, wr_protect, buf_wr;
  logic [5:0]  cmd_strobe;
  logic [95:0] timing_cfg;
  logic [31:0] op_addr, buf_wdata;
  logic [2:0]  buf_slot;

  always #4 clk = ~clk;

  nvmr_protreg_if dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_busy(eng_busy),
    .redun_off(redun_off), .discharged(discharged), .brown_out(brown_out),
    .sleep_en(sleep_en), .wr_protect(wr_protect), .cmd_strobe(cmd_strobe),
    .timing_cfg(timing_cfg), .op_addr(op_addr), .buf_wr(buf_wr),
    .buf_slot(buf_slot), .buf_wdata(buf_wdata)
  );

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  item_t cur;
  logic [31:0] act;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Monitor: pops one expected item per falling edge and compares.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      cur = sb_q.pop_front();
      case (cur.kind)
        0: act = bus_rdata;
        1: act = {26'd0, cmd_strobe};
        2: act = {31'd0, wr_protect};
        3: act = {28'd0, buf_wr, buf_slot};
        4: act = buf_wdata;
        5: act = {31'd0, sleep_en};
        6: act = timing_cfg[63:32];
        default: act = op_addr;
      endcase
      checks++;
      if (act !== cur.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", cur.tag, cur.kind, act, cur.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    step();
    bus_we    = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic chk(input int kind, input logic [5:0] a, input logic [31:0] e, input string tag);
    item_t it;
    bus_addr = a;
    it.kind = kind;
    it.exp  = e;
    it.tag  = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic key_seq();
    wr(6'h18, 32'h7123);
    wr(6'h1C, 32'h812A);
    wr(6'h18, 32'hBEE1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk(0, 6'h00, 32'h2, "R1 control");
    chk(2, 6'h00, 32'h1, "R1 protect");
    chk(0, 6'h2C, 32'h0, "R1 status");
    chk(1, 6'h00, 32'h0, "R1 strobe");
    chk(3, 6'h00, 32'h0, "R1 buffer pulse");
    chk(0, 6'h04, 32'h0, "R1 timing");

    // R2 protected writes dropped
    wr(6'h04, 32'h1234);
    chk(0, 6'h04, 32'h0, "R2 timing blocked");
    chk(0, 6'h2C, 32'h2, "R2 error set");
    wr(6'h24, 32'h55);
    chk(3, 6'h00, 32'h0, "R2 no buffer pulse");
    wr(6'h00, 32'h1F9);
    chk(1, 6'h00, 32'h0, "R2 no strobe");
    chk(0, 6'h00, 32'h2, "R2 control blocked");

    // R7 status clear
    wr(6'h2C, 32'h0);
    chk(0, 6'h2C, 32'h2, "R7 zero keeps error");
    wr(6'h2C, 32'h2);
    chk(0, 6'h2C, 32'h0, "R7 one clears error");

    // R4 broken key sequences
    wr(6'h18, 32'h7123); wr(6'h1C, 32'h812A); wr(6'h18, 32'hBEE0);
    wr(6'h00, 32'h0);
    chk(0, 6'h00, 32'h2, "R4 wrong third value");
    chk(0, 6'h2C, 32'h2, "R4 wrong value error");
    wr(6'h2C, 32'h2);
    wr(6'h18, 32'h7123); wr(6'h20, 32'h5); wr(6'h1C, 32'h812A); wr(6'h18, 32'hBEE1);
    wr(6'h00, 32'h0);
    chk(0, 6'h00, 32'h2, "R4 interleaved write");
    wr(6'h2C, 32'h2);
    wr(6'h18, 32'h7123); wr(6'h18, 32'h7123); wr(6'h1C, 32'h812A); wr(6'h18, 32'hBEE1);
    wr(6'h00, 32'h0);
    chk(0, 6'h00, 32'h2, "R4 repeated step");
    wr(6'h2C, 32'h2);
    chk(0, 6'h2C, 32'h0, "R4 error cleared");

    // R3 proper key opens protect
    key_seq();
    wr(6'h00, 32'h0);
    chk(0, 6'h00, 32'h0, "R3 control after key");
    chk(2, 6'h00, 32'h0, "R3 protect off");
    chk(0, 6'h2C, 32'h0, "R3 no error");

    // R6 unprotected control write without key
    wr(6'h00, 32'h3);
    chk(0, 6'h00, 32'h1, "R6 sleep set wp kept");
    chk(5, 6'h00, 32'h1, "R6 sleep port");
    chk(0, 6'h2C, 32'h0, "R6 no error");

    // R9 command strobes
    wr(6'h00, 32'h1F9);
    chk(1, 6'h00, 32'h3F, "R9 all strobes");
    chk(1, 6'h00, 32'h0, "R9 strobe one cycle");
    chk(0, 6'h00, 32'h1, "R9 command bits read zero");
    wr(6'h00, 32'h20);
    chk(1, 6'h00, 32'h4, "R9 program strobe");
    chk(0, 6'h00, 32'h0, "R9 sleep cleared");

    // R11 readback
    wr(6'h04, 32'hDEADBEEF);
    wr(6'h08, 32'h00ABCDEF);
    wr(6'h0C, 32'h0F12ABCD);
    chk(0, 6'h04, 32'hDEADBEEF, "R11 timing0");
    chk(0, 6'h0C, 32'h0F12ABCD, "R11 timing2");
    chk(6, 6'h00, 32'h00ABCDEF, "R11 timing port word1");
    wr(6'h20, 32'h1000);
    chk(0, 6'h20, 32'h1000, "R11 address");
    chk(7, 6'h00, 32'h1000, "R11 address port");
    wr(6'h34, 32'h7F001);
    chk(0, 6'h34, 32'h7F001, "R11 redundancy1");
    wr(6'h10, 32'hFFFF);
    chk(0, 6'h10, 32'h0, "R11 unmapped reads zero");
    chk(0, 6'h18, 32'h0, "R11 key offset reads zero");
    chk(0, 6'h2C, 32'h0, "R11 unmapped no error");

    // R10 program buffer
    wr(6'h28, 32'h6);
    chk(0, 6'h28, 32'h6, "R10 index set");
    wr(6'h24, 32'hA5);
    chk(3, 6'h00, 32'hE, "R10 pulse slot6");
    chk(4, 6'h00, 32'hA5, "R10 data");
    wr(6'h24, 32'h5A);
    chk(3, 6'h00, 32'hF, "R10 pulse slot7");
    chk(3, 6'h00, 32'h7, "R10 pulse ends");
    chk(0, 6'h28, 32'h0, "R10 index wraps");

    // R8 status inputs
    eng_busy = 1'b1; brown_out = 1'b1;
    chk(0, 6'h2C, 32'h11, "R8 busy brown-out");
    redun_off = 1'b1; discharged = 1'b1; eng_busy = 1'b0; brown_out = 1'b0;
    chk(0, 6'h2C, 32'hC, "R8 redundancy discharged");
    redun_off = 1'b0; discharged = 1'b0;

    // R5 key consumption
    key_seq();
    wr(6'h2C, 32'h2);
    wr(6'h00, 32'h2);
    chk(2, 6'h00, 32'h1, "R5 key survives other write");
    wr(6'h00, 32'h0);
    chk(0, 6'h00, 32'h2, "R5 key used up");
    chk(0, 6'h2C, 32'h2, "R5 blocked sets error");
    wr(6'h2C, 32'h2);
    key_seq();
    wr(6'h00, 32'h2);
    wr(6'h00, 32'h0);
    chk(2, 6'h00, 32'h1, "R5 second write no change");
    chk(0, 6'h2C, 32'h2, "R5 second write blocked");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule